// File: doc/BRIEF.md
# Masked Block Write Controller

This block decodes memory cycles from an active-low row strobe and an active-low column strobe, plus a handful of control inputs. It writes into a small word array that it owns. The control inputs are a transfer gate, a function select and a write strobe.

In a block write, one column cycle copies a stored color value into all four columns of an aligned column group. Each of those four columns can be suppressed by a column mask, which arrives on the low data inputs. Each data bit can also be protected by an I/O mask, which is either applied or not for the whole row cycle. The write strobe level at the row strobe fall makes that choice.

Dedicated load cycles fill the color register and the I/O mask register. The controller also performs ordinary single-column writes and reads, so the array contents can be observed through the normal interface. All strobes are sampled on the system clock, and a strobe edge is recognised at the first clock edge that sees the new level.

Top module: `bwc_top`

## Requirements
- R1: On reset the row is closed (`row_open`=0), `wr_col_en`=0, `dq_out_vld`=0, every array word is 0, and the color register and the I/O mask register are both 0.
- R2: When `row_stb_n` falls, the row opens only if `col_stb_n`=1 and `xfer_n`=1 at that edge. Either one low leaves the row closed, and later column strobe falls do nothing until `row_stb_n` rises and falls again. `addr[2:0]` at the row fall selects the row, and a rise of `row_stb_n` closes the row.
- R3: In a row opened with `func_sel`=0, the level of `wr_n` at the row fall sets the mask mode for the whole row. `wr_n`=0 applies the I/O mask to every write in the row, where mask bit value 1 lets that data bit be written and 0 keeps the old bit. `wr_n`=1 writes all bits.
- R4: In such a row, a column strobe fall with `func_sel`=1 is a block write. It writes the color register into the columns {addr[5:2],k} for k=0..3, and addr[1:0] has no effect.
- R5: In a block write, `dq_in[k]`=1 enables the write to column {group,k} and 0 leaves that column unchanged. During the cycle after the edge, `wr_col_en` bit k shows which columns are being written.
- R6: A row opened with `func_sel`=1 is a load row. A column fall in it with `wr_n`=0 loads `dq_in` into the color register when `func_sel`=1, or into the I/O mask register when `func_sel`=0. Both registers keep their values across later rows until they are loaded again.
- R7: In a row opened with `func_sel`=0, a column fall with `func_sel`=0 and `wr_n`=0 writes `dq_in` to column `addr`, with the R3 mask mode applied. Only `wr_col_en` bit addr[1:0] is raised.
- R8: In a row opened with `func_sel`=0, a column fall with `func_sel`=0 and `wr_n`=1 is a read. `dq_out` carries the addressed word while `dq_out_vld` is high for one cycle, and no column is written.
- R9: A column fall seen at clock edge k drives `wr_col_en` from just after edge k until edge k+1. All four column writes land in the array at edge k+1, and read data is valid from just after edge k+1.
- R10: A column strobe fall while no row is open writes nothing and raises no `wr_col_en` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | 1 | Column strobe, active low |
| xfer_n | input | 1 | Transfer gate; low at the row fall blocks the row |
| func_sel | input | 1 | Function select, sampled at both strobe falls |
| wr_n | input | 1 | Write strobe, active low; sets the mask mode at the row fall |
| addr | input | 6 | Row address at the row fall, column address at the column fall |
| dq_in | input | 8 | Write data, column mask or register load value |
| dq_out | output | 8 | Read data |
| dq_out_vld | output | 1 | One-cycle read data valid |
| wr_col_en | output | 4 | Column write enables of the current group |
| row_open | output | 1 | A row cycle is open |

## Verification
A row strobe fall shows on `row_open` just after the clock edge that samples it. A column strobe fall shows on `wr_col_en` during the following clock cycle, and on the array contents and `dq_out` one edge later. The bench changes strobes only on falling clock edges. It then checks `wr_col_en` at the next falling edge, and read data and `dq_out_vld` at the falling edge after that. Every write and read is compared against a bench memory model. The model is updated by functions built from the mask rules, so the checks land exactly in those cycles.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
    localparam int ADDR_W  = 6;
    localparam int ROW_W   = 3;
    localparam int DQ_W    = 8;
    localparam int LANE_W  = 2;
    localparam int LANES   = 1 << LANE_W;
    localparam int GROUP_W = ADDR_W - LANE_W;
    localparam int ROWS    = 1 << ROW_W;
    localparam int COLS    = 1 << ADDR_W;
    localparam int WORDS   = ROWS * COLS;
    localparam int IDX_W   = ROW_W + ADDR_W;

    typedef enum logic [1:0] {
        ROW_CLOSED,
        ROW_RAM,
        ROW_LOAD
    } row_state_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_BLOCK,
        CMD_WRITE,
        CMD_READ,
        CMD_LD_COLOR,
        CMD_LD_MASK
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e             kind;
        logic                  use_iomask;
        logic [ROW_W-1:0]      row;
        logic [ADDR_W-1:0]     col;
        logic [DQ_W-1:0]       data;
    } col_cmd_t;

    typedef struct packed {
        logic [LANES-1:0]      lane_en;
        logic [ROW_W-1:0]      row;
        logic [GROUP_W-1:0]    group;
        logic [DQ_W-1:0]       word;
        logic [DQ_W-1:0]       bitmask;
    } lane_wr_t;

    function automatic logic [DQ_W-1:0] merge_bits(
        input logic [DQ_W-1:0] old_w,
        input logic [DQ_W-1:0] new_w,
        input logic [DQ_W-1:0] keep_n
    );
        return (old_w & ~keep_n) | (new_w & keep_n);
    endfunction

    function automatic logic [LANES-1:0] lane_select(input logic [LANE_W-1:0] sel);
        logic [LANES-1:0] v;
        v = '0;
        v[sel] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/bwc_cycle_decode.sv
module bwc_cycle_decode
    import bwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              row_stb_n,
    input  logic              col_stb_n,
    input  logic              xfer_n,
    input  logic              func_sel,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output col_cmd_t          cmd_q,
    output logic              row_open
);
    logic             row_prev_q;
    logic             col_prev_q;
    row_state_e       state_q;
    logic             mask_mode_q;
    logic [ROW_W-1:0] row_q;
    logic             row_fall;
    logic             row_rise;
    logic             col_fall;
    col_cmd_t         cmd_d;

    assign row_fall = row_prev_q & ~row_stb_n;
    assign row_rise = ~row_prev_q & row_stb_n;
    assign col_fall = col_prev_q & ~col_stb_n;
    assign row_open = (state_q != ROW_CLOSED);

    always_ff @(posedge clk) begin
        if (rst) begin
            row_prev_q  <= 1'b1;
            col_prev_q  <= 1'b1;
            state_q     <= ROW_CLOSED;
            mask_mode_q <= 1'b0;
            row_q       <= '0;
        end else begin
            row_prev_q <= row_stb_n;
            col_prev_q <= col_stb_n;
            if (row_rise) begin
                state_q <= ROW_CLOSED;
            end else if (row_fall && col_stb_n && xfer_n) begin
                state_q     <= func_sel ? ROW_LOAD : ROW_RAM;
                mask_mode_q <= ~wr_n;
                row_q       <= addr[ROW_W-1:0];
            end
        end
    end

    always_comb begin
        cmd_d            = '0;
        cmd_d.kind       = CMD_NONE;
        cmd_d.use_iomask = mask_mode_q;
        cmd_d.row        = row_q;
        cmd_d.col        = addr;
        cmd_d.data       = dq_in;
        if (col_fall && !row_stb_n) begin
            unique case (state_q)
                ROW_RAM: begin
                    if (func_sel)   cmd_d.kind = CMD_BLOCK;
                    else if (!wr_n) cmd_d.kind = CMD_WRITE;
                    else            cmd_d.kind = CMD_READ;
                end
                ROW_LOAD: begin
                    if (!wr_n) cmd_d.kind = func_sel ? CMD_LD_COLOR : CMD_LD_MASK;
                end
                default: cmd_d.kind = CMD_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q      <= '0;
            cmd_q.kind <= CMD_NONE;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    AST_CMD_NEEDS_ROW: assert property (@(posedge clk) disable iff (rst)
        (cmd_q.kind != CMD_NONE) |-> $past(state_q != ROW_CLOSED)); // R10

    AST_ROW_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (!row_prev_q && row_stb_n) |=> (state_q == ROW_CLOSED)); // R2
endmodule

// File: rtl/bwc_mask_regs.sv
module bwc_mask_regs
    import bwc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  col_cmd_t        cmd,
    output logic [DQ_W-1:0] color_q,
    output logic [DQ_W-1:0] iomask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            color_q  <= '0;
            iomask_q <= '0;
        end else begin
            if (cmd.kind == CMD_LD_COLOR) color_q  <= cmd.data;
            if (cmd.kind == CMD_LD_MASK)  iomask_q <= cmd.data;
        end
    end

    AST_COLOR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind != CMD_LD_COLOR) |=> $stable(color_q)); // R6

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd.kind != CMD_LD_MASK) |=> $stable(iomask_q)); // R6
endmodule

// File: rtl/bwc_lane_gen.sv
module bwc_lane_gen
    import bwc_pkg::*;
(
    input  col_cmd_t        cmd,
    input  logic [DQ_W-1:0] color,
    input  logic [DQ_W-1:0] iomask,
    output lane_wr_t        wr
);
    always_comb begin
        wr.row     = cmd.row;
        wr.group   = cmd.col[ADDR_W-1:LANE_W];
        wr.bitmask = cmd.use_iomask ? iomask : {DQ_W{1'b1}};
        wr.word    = cmd.data;
        wr.lane_en = '0;
        unique case (cmd.kind)
            CMD_BLOCK: begin
                wr.word    = color;
                wr.lane_en = cmd.data[LANES-1:0];
            end
            CMD_WRITE: begin
                wr.lane_en = lane_select(cmd.col[LANE_W-1:0]);
            end
            default: wr.lane_en = '0;
        endcase
    end
endmodule

// File: rtl/bwc_cell_array.sv
module bwc_cell_array
    import bwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lane_wr_t          wr,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_out_vld
);
    logic [DQ_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
            dq_out     <= '0;
            dq_out_vld <= 1'b0;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (wr.lane_en[l]) begin
                    mem[{wr.row, wr.group, l[LANE_W-1:0]}] <=
                        merge_bits(mem[{wr.row, wr.group, l[LANE_W-1:0]}], wr.word, wr.bitmask);
                end
            end
            dq_out_vld <= rd_en;
            if (rd_en) dq_out <= mem[rd_idx];
        end
    end

    AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (wr.lane_en == '0)); // R8

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        dq_out_vld |=> !dq_out_vld); // R8
endmodule

// File: rtl/bwc_top.sv
module bwc_top
    import bwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              row_stb_n,
    input  logic              col_stb_n,
    input  logic              xfer_n,
    input  logic              func_sel,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_out_vld,
    output logic [LANES-1:0]  wr_col_en,
    output logic              row_open
);
    col_cmd_t        cmd;
    logic [DQ_W-1:0] color;
    logic [DQ_W-1:0] iomask;
    lane_wr_t        wr;
    logic            rd_en;

    bwc_cycle_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .row_stb_n (row_stb_n),
        .col_stb_n (col_stb_n),
        .xfer_n    (xfer_n),
        .func_sel  (func_sel),
        .wr_n      (wr_n),
        .addr      (addr),
        .dq_in     (dq_in),
        .cmd_q     (cmd),
        .row_open  (row_open)
    );

    bwc_mask_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .color_q  (color),
        .iomask_q (iomask)
    );

    bwc_lane_gen u_lanes (
        .cmd    (cmd),
        .color  (color),
        .iomask (iomask),
        .wr     (wr)
    );

    assign rd_en     = (cmd.kind == CMD_READ);
    assign wr_col_en = wr.lane_en;

    bwc_cell_array u_array (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr),
        .rd_en      (rd_en),
        .rd_idx     ({cmd.row, cmd.col}),
        .dq_out     (dq_out),
        .dq_out_vld (dq_out_vld)
    );

    AST_WRITE_IN_OPEN_ROW: assert property (@(posedge clk) disable iff (rst)
        (wr_col_en != '0) |-> $past(row_open)); // R10
endmodule

// File: tb/bwc_top_bench.sv
module bwc_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       row_stb_n = 1'b1;
    logic       col_stb_n = 1'b1;
    logic       xfer_n = 1'b1;
    logic       func_sel = 1'b0;
    logic       wr_n = 1'b1;
    logic [5:0] addr = '0;
    logic [7:0] dq_in = '0;
    logic [7:0] dq_out;
    logic       dq_out_vld;
    logic [3:0] wr_col_en;
    logic       row_open;

    int checks = 0;
    int failures = 0;

    logic [7:0] model [8][64];
    logic [7:0] m_color = '0;
    logic [7:0] m_mask = '0;
    int         cur_row = 0;
    bit         cur_masked = 0;

    always #2 clk = ~clk;

    bwc_top u_bwc_top (
        .clk(clk), .rst(rst), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
        .xfer_n(xfer_n), .func_sel(func_sel), .wr_n(wr_n), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_out_vld(dq_out_vld),
        .wr_col_en(wr_col_en), .row_open(row_open)
    );

    function automatic logic [7:0] apply(input logic [7:0] o, input logic [7:0] n, input bit masked, input logic [7:0] m);
        logic [7:0] k;
        k = masked ? m : 8'hFF;
        return (o & ~k) | (n & k);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic open_row(input int r, input bit f, input bit w, input bit x, input bit c);
        @(negedge clk);
        addr = 6'(r); func_sel = f; wr_n = w; xfer_n = x; col_stb_n = c; row_stb_n = 1'b0;
        @(negedge clk);
        xfer_n = 1'b1; col_stb_n = 1'b1;
        @(negedge clk);
        cur_row = r; cur_masked = !w;
    endtask

    task automatic close_row;
        row_stb_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic col_op(input int c, input bit f, input bit w, input logic [7:0] d,
                          input logic [3:0] exp_en, input string tag,
                          input bit chk_rd, input logic [7:0] exp_rd);
        addr = 6'(c); func_sel = f; wr_n = w; dq_in = d; col_stb_n = 1'b0;
        @(negedge clk);
        chk(wr_col_en == exp_en, tag, wr_col_en, exp_en);
        @(negedge clk);
        if (chk_rd) begin
            chk(dq_out_vld == 1'b1, "R8 valid", dq_out_vld, 1);
            chk(dq_out == exp_rd, tag, dq_out, exp_rd);
        end else begin
            chk(dq_out_vld == 1'b0, "R8 no valid", dq_out_vld, 0);
        end
        col_stb_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_block(input int c, input logic [3:0] cm);
        int g;
        g = c & ~3;
        col_op(c, 1, 0, {4'h0, cm}, cm, "R5 block enables", 0, 0);
        for (int k = 0; k < 4; k++)
            if (cm[k]) model[cur_row][g+k] = apply(model[cur_row][g+k], m_color, cur_masked, m_mask);
    endtask

    task automatic do_write(input int c, input logic [7:0] d);
        col_op(c, 0, 0, d, 4'(1 << (c & 3)), "R7 write enable", 0, 0);
        model[cur_row][c] = apply(model[cur_row][c], d, cur_masked, m_mask);
    endtask

    task automatic do_read(input int c, input string tag);
        col_op(c, 0, 1, 8'h00, 4'h0, tag, 1, model[cur_row][c]);
    endtask

    task automatic load_regs(input logic [7:0] col, input logic [7:0] msk);
        open_row(0, 1, 1, 1, 1);
        chk(row_open == 1'b1, "R6 load row open", row_open, 1);
        col_op(0, 1, 0, col, 4'h0, "R6 color load no write", 0, 0);
        col_op(0, 0, 0, msk, 4'h0, "R6 mask load no write", 0, 0);
        close_row();
        m_color = col; m_mask = msk;
    endtask

    initial begin
        #(4 * 190000);
        chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 64; c++) model[r][c] = '0;
        void'($urandom(32'd20250611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(row_open == 1'b0, "R1 row closed", row_open, 0);
        chk(wr_col_en == 4'h0, "R1 no enables", wr_col_en, 0);
        chk(dq_out_vld == 1'b0, "R1 no valid", dq_out_vld, 0);

        // R1: memory zero and color register zero
        open_row(1, 0, 1, 1, 1);
        chk(row_open == 1'b1, "R2 row opens", row_open, 1);
        do_read(5, "R1 array zero");
        do_write(9, 8'hFF);
        do_block(9, 4'hF);
        do_read(9, "R1 color reset zero");
        close_row();
        chk(row_open == 1'b0, "R2 row closes", row_open, 0);

        // R6 loads, R4 low column bits ignored, R5 column mask, R9 timing
        load_regs(8'hA5, 8'h0F);
        open_row(3, 0, 1, 1, 1);
        do_block(13, 4'b1011);
        for (int c = 12; c < 16; c++) do_read(c, "R4 block data");
        do_read(11, "R4 outside group untouched");
        close_row();

        // R3 masked mode, R7 masked normal write
        open_row(5, 0, 0, 1, 1);
        do_write(7, 8'hFF);
        do_read(7, "R3 masked write");
        do_block(2, 4'hF);
        for (int c = 0; c < 4; c++) do_read(c, "R3 masked block");
        close_row();

        // R10 column strobe with row closed
        addr = 6'd0; func_sel = 1'b1; wr_n = 1'b0; dq_in = 8'h0F; col_stb_n = 1'b0;
        @(negedge clk);
        chk(wr_col_en == 4'h0, "R10 closed row no enables", wr_col_en, 0);
        col_stb_n = 1'b1;
        @(negedge clk);

        // R2 transfer gate low and column low at row fall block the row
        open_row(3, 0, 1, 0, 1);
        chk(row_open == 1'b0, "R2 transfer blocks row", row_open, 0);
        col_op(12, 1, 0, 8'h0F, 4'h0, "R2 blocked row no write", 0, 0);
        close_row();
        open_row(3, 0, 1, 1, 0);
        chk(row_open == 1'b0, "R2 column low blocks row", row_open, 0);
        close_row();
        open_row(3, 0, 1, 1, 1);
        do_read(14, "R2 blocked rows left data");
        close_row();

        // Random mix
        for (int it = 0; it < 120; it++) begin
            if (it % 15 == 0) load_regs(8'($urandom), 8'($urandom));
            open_row(int'($urandom % 8), 0, bit'($urandom % 2), 1, 1);
            for (int op = 0; op < 4; op++) begin
                int c;
                int sel;
                c = int'($urandom % 64);
                sel = int'($urandom % 3);
                if (sel == 0) do_block(c, 4'($urandom));
                else if (sel == 1) do_write(c, 8'($urandom));
                else do_read(c, "R4 R7 random readback");
            end
            do_read(int'($urandom % 64), "R6 R3 random readback");
            close_row();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule